// File: doc/BRIEF.md
# Wake-Up Event Interrupt Controller

This block gathers wake-up events from five fixed sources and folds them into a single interrupt request to a host. The request is active low. The sources are an external active-low interrupt pin, a wake-up timer expiry, a low-supply detector, a receive FIFO reaching full, and a request arriving over the serial control link. The supply detector compares against a threshold that is programmable in 0.1 V steps from 2.2 V to 5.3 V. That detector, the timer and the serial shifter all live outside this block; only their event outputs come in.

Each source owns one bit of a status word. The bit records that the source fired, and it stays set until the host reads the word. The serial logic reads the status and then pulses a clear strobe, which empties every flag. A per-source mask decides whether a latched flag may pull the request low. Masked causes are still recorded in the status word. The external pin is asynchronous, so it is synchronised before use, and only its falling edge counts as an event.

Top module: `wk_intc`

## Requirements
- R1: After reset, every status bit is 0 and `irq_n` is 1.
- R2: A falling edge on `ext_int_n` sets status bit 0 exactly three clock edges after the first edge that samples the low level. Holding the pin low sets it only once. A rising edge sets nothing.
- R3: A high level on `tmr_expire`, `lowv_det`, `fifo_full` or `host_req` at a clock edge sets status bit 1, 2, 3 or 4 respectively at that edge.
- R4: A set status bit stays set while `rd_clr` is low.
- R5: A clock edge with `rd_clr` high clears every status bit whose source has no event at that edge.
- R6: A source event at the same edge as `rd_clr` leaves that source's status bit set.
- R7: `irq_n` goes low one clock edge after any status bit with a 0 in the same position of `src_mask` is set.
- R8: A status bit whose `src_mask` bit is 1 is still latched, but it alone never drives `irq_n` low.
- R9: `irq_n` returns to 1 one clock edge after the last unmasked set status bit clears, or after its mask bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_int_n | input | 1 | External interrupt pin, asynchronous, active low |
| tmr_expire | input | 1 | Wake-up timer expiry event |
| lowv_det | input | 1 | Low-supply detector event |
| fifo_full | input | 1 | Receive FIFO full event |
| host_req | input | 1 | Wake request from the serial link |
| rd_clr | input | 1 | Status-read strobe, clears the flags |
| src_mask | input | 5 | Per-source mask, 1 blocks the interrupt (bit order as in status) |
| irq_n | output | 1 | Interrupt request, active low |
| status | output | 5 | Latched causes: bit0 pin, bit1 timer, bit2 supply, bit3 FIFO, bit4 serial |

## Verification
A flag that fails to latch, or one that clears on its own, shows on `status` at the very next edge. Through the request line it shows one edge after that. A fault in the synchroniser shifts the status bit 0 set by a cycle, or sets it twice during a held-low pulse, and the bench checks that edge exactly. Faults in the clear priority or the masking appear on the first read that coincides with an event, and on the first masked event. The bench drives both of these as directed cases, and also throws random traffic against a cycle model.

// File: rtl/wk_pkg.sv
// Package: shared constants for the wake-up interrupt controller.
// Assumes the source order below matches the status-word bit order.
package wk_pkg;
    localparam int NUM_SRC     = 5;
    localparam int SYNC_STAGES = 2;
    localparam int SRC_PIN     = 0;
    localparam int SRC_TIMER   = 1;
    localparam int SRC_SUPPLY  = 2;
    localparam int SRC_FIFO    = 3;
    localparam int SRC_SERIAL  = 4;
    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/wk_edge_sync.sv
// Module: wk_edge_sync
// Synchronises an asynchronous active-low pin through STAGES flops and
// emits a one-cycle pulse on each falling edge of the synchronised level.
// Assumes STAGES >= 2; all flops reset to the idle (high) level.
module wk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_n};
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain[STAGES-1];
    end

    // Falling edge: was high, now low.
    always_comb fall_pulse = last_q & ~chain[STAGES-1];

    // A falling edge pulse lasts exactly one cycle.
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/wk_flag_bank.sv
// Module: wk_flag_bank
// One sticky flag per source. An event sets its flag; the clear strobe
// empties all flags, but an event on the same edge wins over the clear.
// Assumes events are synchronous to clk.
module wk_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_in,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Set on event, clear on strobe unless an event coincides.
        always_ff @(posedge clk) begin
            if (!rst_n)           flags[i] <= 1'b0;
            else if (event_in[i]) flags[i] <= 1'b1;
            else if (clr)         flags[i] <= 1'b0;
        end

        assert_set_on_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
            event_in[i] |=> flags[i]);
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr) |=> flags[i]);
        assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !event_in[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/wk_irq_drive.sv
// Module: wk_irq_drive
// Registers the active-low request from the latched flags and the mask.
// A mask bit of 1 keeps its flag from requesting. Output lags by one edge.
module wk_irq_drive #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    output logic         irq_n
);
    logic pending;

    // Any unmasked latched cause.
    always_comb pending = |(flags & ~mask);

    // Register the request so the pin is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~pending;
    end

    assert_irq_assert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~mask)) |=> !irq_n);
    assert_irq_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags & ~mask)) |=> irq_n);
endmodule

// File: rtl/wk_intc.sv
// Module: wk_intc (top)
// Collects the five wake-up sources, latches the causes in a status word
// cleared by a read strobe, and drives an active-low interrupt request.
// Assumes all inputs except ext_int_n are synchronous to clk.
module wk_intc
    import wk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_int_n,
    input  logic               tmr_expire,
    input  logic               lowv_det,
    input  logic               fifo_full,
    input  logic               host_req,
    input  logic               rd_clr,
    input  logic [NUM_SRC-1:0] src_mask,
    output logic               irq_n,
    output logic [NUM_SRC-1:0] status
);
    logic     pin_fall;
    src_vec_t events;

    wk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(ext_int_n), .fall_pulse(pin_fall)
    );

    // Assemble the event vector in status-bit order.
    always_comb begin
        events             = '0;
        events[SRC_PIN]    = pin_fall;
        events[SRC_TIMER]  = tmr_expire;
        events[SRC_SUPPLY] = lowv_det;
        events[SRC_FIFO]   = fifo_full;
        events[SRC_SERIAL] = host_req;
    end

    wk_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .event_in(events), .clr(rd_clr), .flags(status)
    );

    wk_irq_drive #(.N(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .flags(status), .mask(src_mask), .irq_n(irq_n)
    );

    // Masked-only causes never request.
    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~src_mask) == '0) |=> irq_n);
    // Event together with a read survives.
    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && tmr_expire) |=> status[SRC_TIMER]);
endmodule

// File: tb/wk_intc_test.sv
module wk_intc_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 5;

    logic clk = 0, rst_n = 0;
    logic ext_int_n = 1, tmr_expire = 0, lowv_det = 0, fifo_full = 0, host_req = 0, rd_clr = 0;
    logic [N-1:0] src_mask = '0;
    logic irq_n;
    logic [N-1:0] status;

    int n_tests = 0, n_fail = 0;

    // bench model state
    logic s1 = 1, s2 = 1, s3 = 1;
    logic [N-1:0] m_flags = '0;
    logic m_irq_n = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    wk_intc uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] next_flags(logic [N-1:0] f, logic [N-1:0] ev, logic clr);
        return clr ? ev : (f | ev);
    endfunction

    function automatic logic next_irq(logic [N-1:0] f, logic [N-1:0] m);
        return ~|(f & ~m);
    endfunction

    // One cycle: inputs held from the previous negedge; update model; compare.
    task automatic step(string req);
        logic [N-1:0] ev;
        @(posedge clk);
        ev = {host_req, fifo_full, lowv_det, tmr_expire, (s3 & ~s2)};
        m_irq_n = next_irq(m_flags, src_mask);
        m_flags = next_flags(m_flags, ev, rd_clr);
        s3 = s2; s2 = s1; s1 = ext_int_n;
        @(negedge clk);
        chk(req, status, m_flags);
        chk(req, irq_n, m_irq_n);
    endtask

    task automatic idle();
        tmr_expire = 0; lowv_det = 0; fifo_full = 0; host_req = 0; rd_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", status, 0);
        chk("R1", irq_n, 1);

        // R2 pin edge timing: low sampled at E1, flag visible after E3
        ext_int_n = 0;
        step("R2"); chk("R2", status[0], 0);
        step("R2"); chk("R2", status[0], 0);
        step("R2"); chk("R2", status[0], 1);
        step("R7"); chk("R7", irq_n, 0);
        rd_clr = 1; step("R5"); rd_clr = 0;
        chk("R5", status, 0);
        repeat (5) step("R2");          // held low: no second set
        chk("R2", status[0], 0);
        ext_int_n = 1;
        repeat (5) step("R2");          // rising edge: nothing
        chk("R2", status[0], 0);
        step("R9"); chk("R9", irq_n, 1);

        // R3 internal sources
        tmr_expire = 1; step("R3"); idle(); chk("R3", status, 5'b00010);
        fifo_full = 1;  step("R3"); idle(); chk("R3", status, 5'b01010);
        repeat (4) step("R4");
        chk("R4", status, 5'b01010);

        // R6 event coinciding with read
        rd_clr = 1; lowv_det = 1; step("R6"); idle();
        chk("R6", status, 5'b00100);
        rd_clr = 1; step("R5"); idle();
        step("R9"); chk("R9", irq_n, 1);

        // R8 masked source latched but silent
        src_mask = 5'b10000;
        host_req = 1; step("R8"); idle();
        chk("R8", status, 5'b10000);
        repeat (3) step("R8");
        chk("R8", irq_n, 1);
        // R9 unmask -> request, mask again -> release one edge later
        src_mask = 5'b00000; step("R7"); step("R7"); chk("R7", irq_n, 0);
        src_mask = 5'b10000; step("R9"); step("R9"); chk("R9", irq_n, 1);
        src_mask = '0;
        rd_clr = 1; step("R5"); idle();
        step("R9");

        // random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            tmr_expire = ($urandom % 16) == 0;
            lowv_det   = ($urandom % 20) == 0;
            fifo_full  = ($urandom % 16) == 0;
            host_req   = ($urandom % 24) == 0;
            rd_clr     = ($urandom % 8) == 0;
            if (($urandom % 10) == 0) ext_int_n = ~ext_int_n;
            if (($urandom % 50) == 0) src_mask = N'($urandom);
            step("R4");
        end
        idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule